// File: doc/BRIEF.md
# Static memory bus cycle sequencer

This block runs one external static memory access at a time for a single chip-select bank. A requester offers an access over a valid/ready handshake, carrying a direction, an address, a byte mask and write data. The sequencer then walks the memory pins through a fixed pattern. Chip select goes low first. On writes only, an optional setup gap follows before the write strobe. Next comes a timed access phase, where write enable or output enable is low, and then a single trailing cycle with chip select still held. The block finishes with a one-cycle response pulse that carries the read data or an error flag.

Plain configuration inputs shape each access:
- a strobe-mode bit, which decides whether the four active-low byte-lane strobes also go low on reads;
- a long-wait enable, which replaces both normal wait counts with one larger count;
- a write-lock bit, which rejects writes;
- a setup count, which sets the gap from chip select to write enable;
- separate read and write wait counts, and the long wait count.

Every configuration field is sampled when a request is accepted, so a change made during an access has no effect on that access.

Back-pressure exists only on the request side. `req_ready` is high only while the sequencer is idle. An access is taken on a clock edge where `req_valid` and `req_ready` are both high, and the requester must hold its fields stable until that edge. The response is a plain one-cycle pulse with no back-pressure.

Top module: `smc_cycle_seq`

## Requirements
- R1: After reset, chip select, write enable, output enable and all byte-lane strobes are high (inactive), `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in every cycle in which chip select is low.
- R3: With strobe mode 0, all strobes stay high through a read. During a write's access phase, strobe bit i is low exactly when byte-mask bit i is 1. No strobe is ever low outside the access phase.
- R4: With strobe mode 1, strobe bit i is low during the access phase of both reads and writes exactly when byte-mask bit i is 1.
- R5: With long wait off, a wait count of N holds the access phase for N+1 cycles. Reads use the read count and writes use the write count. Chip select is low for N+2 cycles on a read.
- R6: With long wait on, the long wait count times the access phase of both reads and writes, and the read and write counts have no effect.
- R7: On a write with setup count D, chip select is low for D cycles before write enable goes low. Chip select is low for D+N+2 cycles in total.
- R8: Write enable returns high one cycle before chip select does. Output enable is low only during a read's access phase, and never together with write enable.
- R9: A write accepted while the write-lock bit is 1 gives `rsp_valid`=1 and `rsp_err`=1 in the cycle after acceptance. Chip select, write enable and the strobes stay high.
- R10: A read returns, on `rsp_rdata`, the value of `mem_din` from the last access-phase cycle. A write drives `mem_dout` with the request's write data while write enable is low, with `mem_dout_en` at 1.
- R11: The configuration values present at acceptance govern the whole access. Changes made while the sequencer is busy have no effect until the next acceptance.
- R12: `rsp_err` is 1 only together with `rsp_valid`. Reads and unlocked writes respond with `rsp_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lane_mode | input | 1 | 1: byte strobes also low on reads |
| cfg_long_wait | input | 1 | 1: long wait count times every access |
| cfg_wr_lock | input | 1 | 1: writes are rejected with an error |
| cfg_setup | input | DLY_W | Chip-select-to-write-enable gap in cycles |
| cfg_rd_wait | input | WAIT_W | Read access count N (N+1 cycles) |
| cfg_wr_wait | input | WAIT_W | Write access count N (N+1 cycles) |
| cfg_long_cnt | input | EXT_W | Long wait count |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, can accept |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Access address |
| req_be | input | DATA_W/8 | Byte mask, bit i enables byte i |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was a rejected write |
| rsp_rdata | output | DATA_W | Read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_bls_n | output | DATA_W/8 | Byte-lane strobes, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Memory write data |
| mem_dout_en | output | 1 | Write data drive enable |
| mem_din | input | DATA_W | Memory read data |

## Verification
The bench builds the block with ADDR_W=12, DLY_W=3, WAIT_W=4 and EXT_W=6. These widths make the largest setup gap (7), the largest normal wait (15) and the largest long wait (63) cheap to exercise, so the counter end points are covered without long runs. The 32-bit data width keeps four strobes, enough to see individual lane patterns in both strobe modes. Protected writes are issued back to back with normal accesses, and configuration is changed in mid-access, to cover the sampling rule.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_END    = 2'd3
  } smc_state_t;
endpackage

// File: rtl/smc_req_shadow.sv
// Holds the accepted request and the configuration sampled with it.
module smc_req_shadow #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 10,
  localparam int NB    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              in_write,
  input  logic              in_lane,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [NB-1:0]     in_be,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [CNT_W-1:0]  in_acc,
  output logic              write_q,
  output logic              lane_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [NB-1:0]     be_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [CNT_W-1:0]  acc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      lane_q  <= 1'b0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      acc_q   <= '0;
    end else if (cap) begin
      write_q <= in_write;
      lane_q  <= in_lane;
      addr_q  <= in_addr;
      be_q    <= in_be;
      wdata_q <= in_wdata;
      acc_q   <= in_acc;
    end
  end
endmodule

// File: rtl/smc_wait_timer.sv
// Down counter: loaded with a count, reports when it has reached zero.
module smc_wait_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - CNT_W'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/smc_pin_drive.sv
// Decodes the sequencer state into the memory control pins.
module smc_pin_drive #(
  parameter int NB = 4
) (
  input  smc_pkg::smc_state_t state,
  input  logic                write_q,
  input  logic                lane_q,
  input  logic [NB-1:0]       be_q,
  output logic                cs_n,
  output logic                we_n,
  output logic                oe_n,
  output logic [NB-1:0]       bls_n,
  output logic                dout_en
);
  import smc_pkg::*;

  logic active, access, lanes_on;

  assign active   = (state != ST_IDLE);
  assign access   = (state == ST_ACCESS);
  assign lanes_on = access && (write_q || lane_q);

  assign cs_n    = !active;
  assign we_n    = !(access && write_q);
  assign oe_n    = !(access && !write_q);
  assign dout_en = active && write_q;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign bls_n[i] = !(lanes_on && be_q[i]);
  end
endmodule

// File: rtl/smc_cycle_seq.sv
module smc_cycle_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DLY_W  = 4,
  parameter int WAIT_W = 5,
  parameter int EXT_W  = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_lane_mode,
  input  logic                  cfg_long_wait,
  input  logic                  cfg_wr_lock,
  input  logic [DLY_W-1:0]      cfg_setup,
  input  logic [WAIT_W-1:0]     cfg_rd_wait,
  input  logic [WAIT_W-1:0]     cfg_wr_wait,
  input  logic [EXT_W-1:0]      cfg_long_cnt,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W/8-1:0]   req_be,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  output logic                  rsp_err,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  mem_cs_n,
  output logic                  mem_we_n,
  output logic                  mem_oe_n,
  output logic [DATA_W/8-1:0]   mem_bls_n,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_dout,
  output logic                  mem_dout_en,
  input  logic [DATA_W-1:0]     mem_din
);
  import smc_pkg::*;

  localparam int NB    = DATA_W / 8;
  localparam int MW    = (WAIT_W > DLY_W) ? WAIT_W : DLY_W;
  localparam int CNT_W = (EXT_W > MW) ? EXT_W : MW;

  smc_state_t       state, state_nx;
  logic             accept, blocked, start;
  logic [CNT_W-1:0] acc_live, tmr_val;
  logic             tmr_load, expired;
  logic             write_q, lane_q;
  logic [NB-1:0]    be_q;
  logic [CNT_W-1:0] acc_q;
  logic [DATA_W-1:0] rdata_q;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign blocked   = accept && req_write && cfg_wr_lock;
  assign start     = accept && !blocked;

  // long wait replaces both normal counts
  always_comb begin
    if (cfg_long_wait)  acc_live = CNT_W'(cfg_long_cnt);
    else if (req_write) acc_live = CNT_W'(cfg_wr_wait);
    else                acc_live = CNT_W'(cfg_rd_wait);
  end

  smc_req_shadow #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (start),
    .in_write (req_write),
    .in_lane  (cfg_lane_mode),
    .in_addr  (req_addr),
    .in_be    (req_be),
    .in_wdata (req_wdata),
    .in_acc   (acc_live),
    .write_q  (write_q),
    .lane_q   (lane_q),
    .addr_q   (mem_addr),
    .be_q     (be_q),
    .wdata_q  (mem_dout),
    .acc_q    (acc_q)
  );

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = acc_live;
    unique case (state)
      ST_IDLE: if (start) begin
        tmr_load = 1'b1;
        if (req_write && cfg_setup != '0) begin
          state_nx = ST_SETUP;
          tmr_val  = CNT_W'(cfg_setup) - CNT_W'(1);
        end else begin
          state_nx = ST_ACCESS;
          tmr_val  = acc_live;
        end
      end
      ST_SETUP: if (expired) begin
        state_nx = ST_ACCESS;
        tmr_load = 1'b1;
        tmr_val  = acc_q;
      end
      ST_ACCESS: if (expired) state_nx = ST_END;
      ST_END:    state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  smc_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rdata_q   <= '0;
    end else begin
      state     <= state_nx;
      rsp_valid <= blocked || (state == ST_END);
      rsp_err   <= blocked;
      if (state == ST_ACCESS && expired && !write_q) rdata_q <= mem_din;
    end
  end

  assign rsp_rdata = rdata_q;

  smc_pin_drive #(.NB(NB)) u_pins (
    .state   (state),
    .write_q (write_q),
    .lane_q  (lane_q),
    .be_q    (be_q),
    .cs_n    (mem_cs_n),
    .we_n    (mem_we_n),
    .oe_n    (mem_oe_n),
    .bls_n   (mem_bls_n),
    .dout_en (mem_dout_en)
  );
endmodule

// File: rtl/smc_cycle_seq_chk.sv
module smc_cycle_seq_chk #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic          cfg_wr_lock,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic          mem_cs_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic [NB-1:0] mem_bls_n,
  input logic          lane_q
);
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);
  a_r3_strobes_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_bls_n != '1) |-> !mem_cs_n);
  a_r3_read_strobes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && !lane_q) |-> (mem_bls_n == '1));
  a_r8_we_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);
  a_r8_oe_excludes_we: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_cs_n && mem_we_n));
  a_r8_we_release_early: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_cs_n);
  a_r9_locked_write_error: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && cfg_wr_lock) |=>
      (rsp_valid && rsp_err && mem_cs_n));
  a_r11_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (req_ready || $stable(lane_q)));
  a_r12_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
endmodule

bind smc_cycle_seq smc_cycle_seq_chk #(.NB(DATA_W/8)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .cfg_wr_lock (cfg_wr_lock),
  .rsp_valid   (rsp_valid),
  .rsp_err     (rsp_err),
  .mem_cs_n    (mem_cs_n),
  .mem_we_n    (mem_we_n),
  .mem_oe_n    (mem_oe_n),
  .mem_bls_n   (mem_bls_n),
  .lane_q      (lane_q)
);

// File: tb/test_smc_cycle_seq.sv
module test_smc_cycle_seq;
  localparam int AW = 12, DW = 32, DLW = 3, WW = 4, EW = 6, NB = DW / 8;

  logic clk = 0, rst_n = 0;
  logic cfg_lane_mode = 0, cfg_long_wait = 0, cfg_wr_lock = 0;
  logic [DLW-1:0] cfg_setup = 0;
  logic [WW-1:0]  cfg_rd_wait = 0, cfg_wr_wait = 0;
  logic [EW-1:0]  cfg_long_cnt = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = 0;
  logic [NB-1:0] req_be = 0;
  logic [DW-1:0] req_wdata = 0;
  logic req_ready, rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata, mem_dout, mem_din;
  logic mem_cs_n, mem_we_n, mem_oe_n, mem_dout_en;
  logic [NB-1:0] mem_bls_n;
  logic [AW-1:0] mem_addr;

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0], ~a[7:0], a[7:0] + 8'd3};
  endfunction
  assign mem_din = mem_val(mem_addr);

  smc_cycle_seq #(.ADDR_W(AW), .DATA_W(DW), .DLY_W(DLW), .WAIT_W(WW), .EXT_W(EW)) i_smc_cycle_seq (
    .clk(clk), .rst_n(rst_n), .cfg_lane_mode(cfg_lane_mode), .cfg_long_wait(cfg_long_wait),
    .cfg_wr_lock(cfg_wr_lock), .cfg_setup(cfg_setup), .cfg_rd_wait(cfg_rd_wait),
    .cfg_wr_wait(cfg_wr_wait), .cfg_long_cnt(cfg_long_cnt), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_bls_n(mem_bls_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din));

  typedef struct {
    bit        wr, err;
    int        cs, we, oe, dly;
    logic [NB-1:0] bls;
    logic [DW-1:0] data;
    string     ttag, ltag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // driver: computes expectation from the requirements and offers the request
  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [NB-1:0] be,
                       input logic [DW-1:0] wd, input string ttag);
    exp_t e;
    int n;
    n = cfg_long_wait ? int'(cfg_long_cnt) : (wr ? int'(cfg_wr_wait) : int'(cfg_rd_wait));
    e.wr = wr; e.ttag = ttag;
    e.ltag = cfg_lane_mode ? "R4" : "R3";
    if (wr && cfg_wr_lock) begin
      e.err = 1; e.cs = 0; e.we = 0; e.oe = 0; e.dly = 0; e.bls = '1; e.data = '0;
    end else if (wr) begin
      e.err = 0; e.dly = int'(cfg_setup); e.cs = e.dly + n + 2; e.we = n + 1; e.oe = 0;
      e.bls = ~be; e.data = wd;
    end else begin
      e.err = 0; e.dly = 0; e.cs = n + 2; e.we = 0; e.oe = n + 1;
      e.bls = cfg_lane_mode ? ~be : '1; e.data = mem_val(a);
    end
    q.push_back(e);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: measures pin activity and compares at each response
  int cs_c = 0, we_c = 0, oe_c = 0, pre_c = 0;
  bit we_seen = 0, stray = 0, busy_rdy = 0;
  logic [NB-1:0] bls_s = '1;
  logic [DW-1:0] dout_s = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_cs_n) begin
        cs_c++;
        if (req_ready) busy_rdy = 1;
        if (!we_seen && mem_we_n) pre_c++;
      end
      if (!mem_we_n) begin we_c++; we_seen = 1; dout_s = mem_dout; end
      if (!mem_oe_n) oe_c++;
      if (!mem_we_n || !mem_oe_n) bls_s = mem_bls_n;
      else if (mem_bls_n != '1) stray = 1;
      if (rsp_valid) begin
        if (q.size() == 0) check(0, "R12", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          check(rsp_err == e.err, e.err ? "R9" : "R12", rsp_err, e.err);
          check(cs_c == e.cs, e.ttag, cs_c, e.cs);
          check(we_c == e.we, e.ttag, we_c, e.we);
          check(oe_c == e.oe, "R8", oe_c, e.oe);
          check(bls_s == e.bls, e.ltag, bls_s, e.bls);
          check(!stray, "R3", stray, 0);
          check(!busy_rdy, "R2", busy_rdy, 0);
          if (e.wr && !e.err) begin
            check(pre_c == e.dly, "R7", pre_c, e.dly);
            check(dout_s == e.data, "R10", dout_s, e.data);
          end
          if (!e.wr) check(rsp_rdata == e.data, "R10", rsp_rdata, e.data);
        end
        cs_c = 0; we_c = 0; oe_c = 0; pre_c = 0; we_seen = 0; stray = 0; busy_rdy = 0;
        bls_s = '1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mem_cs_n && mem_we_n && mem_oe_n, "R1", {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
    check(mem_bls_n == '1, "R1", mem_bls_n, 4'hF);
    check(req_ready && !rsp_valid, "R1", {req_ready, rsp_valid}, 2'b10);
    rst_n = 1;
    @(negedge clk);

    // R5 / R3 read with strobe mode 0
    cfg_rd_wait = 2; cfg_wr_wait = 1; cfg_setup = 2;
    issue(0, 12'h0A1, 4'b1111, 0, "R5");
    // R7 / R3 write with setup gap and partial mask
    issue(1, 12'h0B2, 4'b0101, 32'hDEAD_BEEF, "R7");
    // write without gap, zero wait
    cfg_setup = 0; cfg_wr_wait = 0;
    issue(1, 12'h0C3, 4'b1111, 32'h1234_5678, "R5");
    drain();
    // R4 strobe mode 1
    cfg_lane_mode = 1; cfg_rd_wait = 0;
    issue(0, 12'h0D4, 4'b0011, 0, "R5");
    cfg_setup = 7; cfg_wr_wait = 15;
    issue(1, 12'h0E5, 4'b1000, 32'hCAFE_0001, "R7");
    drain();
    // R6 long wait replaces both counts
    cfg_lane_mode = 0; cfg_long_wait = 1; cfg_long_cnt = 63; cfg_rd_wait = 1; cfg_setup = 1;
    issue(0, 12'h0F6, 4'b1111, 0, "R6");
    cfg_long_cnt = 5; cfg_wr_wait = 9;
    issue(1, 12'h107, 4'b0110, 32'h0BAD_F00D, "R6");
    drain();
    // R9 locked writes, reads still served
    cfg_long_wait = 0; cfg_wr_lock = 1; cfg_rd_wait = 1;
    issue(1, 12'h118, 4'b1111, 32'hFFFF_FFFF, "R9");
    issue(1, 12'h129, 4'b0001, 32'h0000_0001, "R9");
    issue(0, 12'h13A, 4'b1111, 0, "R12");
    drain();
    // R11 configuration changed mid-access has no effect
    cfg_wr_lock = 0; cfg_rd_wait = 3; cfg_lane_mode = 0;
    issue(0, 12'h14B, 4'b1111, 0, "R11");
    cfg_rd_wait = 9; cfg_lane_mode = 1; cfg_long_wait = 1; cfg_long_cnt = 20;
    drain();
    cfg_long_wait = 0; cfg_setup = 3; cfg_wr_wait = 2; cfg_lane_mode = 0;
    issue(1, 12'h15C, 4'b1100, 32'hA5A5_5A5A, "R11");
    cfg_setup = 0; cfg_wr_wait = 7; cfg_wr_lock = 1;
    drain();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule